// File: doc/BRIEF.md
# Three-phase complementary PWM timer

This block drives a three-phase bridge with three complementary output pairs. A leading counter and a lagging counter advance on one shared count-enable and form two triangle waves. Both rise together and fall together. The leading counter sits a fixed number of counts above the lagging one. That number is the dead-time margin, and it is set by preloading the two counters before start.

Each phase has a transition register. The high-side output of a phase follows the leading counter, and the low-side output follows the lagging counter. When the triangle crosses a transition value, one output of the pair switches off. The other output of the pair switches on a margin's worth of count steps later, so the two sides of a pair are never on together.

Software stops both counters, preloads them, writes the period and the three transition values, and then starts both counters with a single write. Configuration writes made while a counter runs are dropped. Two flags report an illegal setup, evaluated at the moment of start.

Top module: `cpwm3_timer`

## Requirements
- R1: Register map on `wr_addr`:
  - 0: control. Bit 0 runs the leading counter and bit 1 runs the lagging counter.
  - 1: leading counter preload.
  - 2: lagging counter preload.
  - 3: period.
  - 4, 5, 6: transition values of phases 0, 1 and 2.
  
  Writes to addresses 1 to 6 take effect only while both run bits are 0. While either run bit is set, such writes are ignored.
- R2: A running counter moves by one only in cycles where `cnt_en` is 1. Both counters move in the same cycles.
- R3: With both counters running, the leading counter counts up to period+1 and then down. It turns back up when the lagging counter reaches 0. Both counters reverse in the same cycle, so their difference never changes.
- R4: While both counters run, the outputs are registered one cycle after the counter state:
  - `pwm_p[i]` is 1 exactly when the leading counter is below transition i.
  - `pwm_n[i]` is 1 exactly when the lagging counter is at or above transition i.
- R5: `pwm_p[i]` and `pwm_n[i]` are never 1 together. With `cnt_en` held at 1, the low side rises exactly margin cycles after the high side falls.
- R6: While the counters are not both running, all six outputs are 0 from the next cycle on. This includes the state after reset.
- R7: A control write that sets both run bits, while they were not both set, starts both counters on the same edge. At that start, `err_same` is loaded with (leading preload == lagging preload) and then held until the next start.
- R8: At the same start, `err_margin` is loaded with 1 if any transition value is below the leading counter's value, and 0 otherwise. A transition equal to the margin is legal.
- R9: Every start resets the count direction to up. A stop, a reload of the same settings and a new start therefore reproduce the waveform from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Shared count enable for both counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address |
| wr_data | input | CW (16) | Register write data |
| pwm_p | output | PH (3) | High-side output of each phase, active high |
| pwm_n | output | PH (3) | Low-side output of each phase, active high |
| err_same | output | 1 | Both counters were preloaded with equal values at start |
| err_margin | output | 1 | A transition value was below the margin at start |

## Verification
The shoot-through and constant-offset properties assume two things about setup: the lagging counter is preloaded at or below the leading counter, and the period leaves room for the margin. A lagging preload above the leading one is not protected. The stimulus always preloads the lagging counter with 0, or with the same value as the leading counter when it provokes the equal-value flag. Random configurations draw a margin of 1 to 6, a period of at least twice the margin plus six, and transition values between the margin and the lagging counter's peak. Writes during a run, enable gaps and restarts are mixed in on top of that legal setup.

// File: rtl/cpwm3_pkg.sv
`timescale 1ns/1ps
package cpwm3_pkg;
  localparam int ADR_CTRL     = 0;
  localparam int ADR_CNT_A    = 1;
  localparam int ADR_CNT_B    = 2;
  localparam int ADR_PERIOD   = 3;
  localparam int ADR_XPT_BASE = 4;
  localparam int RUN_A_BIT    = 0;
  localparam int RUN_B_BIT    = 1;

  // high side is on while the leading count is under the switching point
  function automatic logic hi_side_on(input logic [31:0] lead, input logic [31:0] xpt);
    return lead < xpt;
  endfunction

  // low side is on while the lagging count is at or over the switching point
  function automatic logic lo_side_on(input logic [31:0] lag, input logic [31:0] xpt);
    return lag >= xpt;
  endfunction

  function automatic logic [31:0] tri_step(input logic [31:0] v, input logic up);
    return up ? v + 32'd1 : v - 32'd1;
  endfunction

  function automatic logic at_peak(input logic [31:0] lead, input logic [31:0] period);
    return lead == period + 32'd1;
  endfunction
endpackage

// File: rtl/cpwm3_regs.sv
`timescale 1ns/1ps
module cpwm3_regs import cpwm3_pkg::*; #(
  parameter int CW = 16,
  parameter int PH = 3,
  parameter int AW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [CW-1:0]          wr_data,
  output logic                   run_a,
  output logic                   run_b,
  output logic                   start_pulse,
  output logic                   ld_a,
  output logic                   ld_b,
  output logic                   wr_dropped,
  output logic [CW-1:0]          period,
  output logic [PH-1:0][CW-1:0]  xpt
);
  logic locked;
  logic ctrl_sel;
  logic cfg_wr;

  assign locked      = run_a | run_b;
  assign ctrl_sel    = wr_en && (wr_addr == AW'(ADR_CTRL));
  assign cfg_wr      = wr_en && !locked && !ctrl_sel;
  assign wr_dropped  = wr_en && locked && !ctrl_sel;
  assign start_pulse = ctrl_sel && wr_data[RUN_A_BIT] && wr_data[RUN_B_BIT] && !(run_a && run_b);
  assign ld_a        = cfg_wr && (wr_addr == AW'(ADR_CNT_A));
  assign ld_b        = cfg_wr && (wr_addr == AW'(ADR_CNT_B));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_a  <= 1'b0;
      run_b  <= 1'b0;
      period <= '0;
    end else begin
      if (ctrl_sel) begin
        run_a <= wr_data[RUN_A_BIT];
        run_b <= wr_data[RUN_B_BIT];
      end
      if (cfg_wr && (wr_addr == AW'(ADR_PERIOD))) period <= wr_data;
    end
  end

  for (genvar g = 0; g < PH; g++) begin : g_xpt
    always_ff @(posedge clk) begin
      if (!rst_n)                                         xpt[g] <= '0;
      else if (cfg_wr && (wr_addr == AW'(ADR_XPT_BASE + g))) xpt[g] <= wr_data;
    end
  end
endmodule

// File: rtl/cpwm3_tri_pair.sv
`timescale 1ns/1ps
module cpwm3_tri_pair import cpwm3_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          run_a,
  input  logic          run_b,
  input  logic          start_pulse,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic          dir_up
);
  logic both;
  logic at_top;
  logic at_bot;
  logic turn;
  logic next_up;

  assign both    = run_a && run_b;
  assign at_top  = at_peak(32'(cnt_a), 32'(period));
  assign at_bot  = (cnt_b == '0);
  assign turn    = both && cnt_en && (dir_up ? at_top : at_bot);
  assign next_up = dir_up ^ turn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_a  <= '0;
      cnt_b  <= '0;
      dir_up <= 1'b1;
    end else begin
      dir_up <= start_pulse ? 1'b1 : next_up;
      if (ld_a)                  cnt_a <= ld_val;
      else if (run_a && cnt_en)  cnt_a <= CW'(tri_step(32'(cnt_a), next_up));
      if (ld_b)                  cnt_b <= ld_val;
      else if (run_b && cnt_en)  cnt_b <= CW'(tri_step(32'(cnt_b), next_up));
    end
  end
endmodule

// File: rtl/cpwm3_phase_out.sv
`timescale 1ns/1ps
module cpwm3_phase_out import cpwm3_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic [CW-1:0] xpt,
  output logic          pos_q,
  output logic          neg_q
);
  logic pos_d;
  logic neg_d;

  assign pos_d = active && hi_side_on(32'(cnt_a), 32'(xpt));
  assign neg_d = active && lo_side_on(32'(cnt_b), 32'(xpt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      neg_q <= neg_d;
    end
  end
endmodule

// File: rtl/cpwm3_cfg_check.sv
`timescale 1ns/1ps
module cpwm3_cfg_check #(
  parameter int CW = 16,
  parameter int PH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_pulse,
  input  logic [CW-1:0]         cnt_a,
  input  logic [CW-1:0]         cnt_b,
  input  logic [PH-1:0][CW-1:0] xpt,
  output logic                  err_same,
  output logic                  err_margin
);
  logic [PH-1:0] below;

  for (genvar g = 0; g < PH; g++) begin : g_below
    assign below[g] = xpt[g] < cnt_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_same   <= 1'b0;
      err_margin <= 1'b0;
    end else if (start_pulse) begin
      err_same   <= (cnt_a == cnt_b);
      err_margin <= |below;
    end
  end
endmodule

// File: rtl/cpwm3_timer.sv
`timescale 1ns/1ps
module cpwm3_timer import cpwm3_pkg::*; #(
  parameter  int CW = 16,
  parameter  int PH = 3,
  localparam int AW = $clog2(ADR_XPT_BASE + PH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [PH-1:0] pwm_p,
  output logic [PH-1:0] pwm_n,
  output logic          err_same,
  output logic          err_margin
);
  logic                  run_a;
  logic                  run_b;
  logic                  both_run;
  logic                  any_run;
  logic                  start_pulse;
  logic                  ld_a;
  logic                  ld_b;
  logic                  wr_dropped;
  logic                  dir_up;
  logic [CW-1:0]         period;
  logic [CW-1:0]         cnt_a;
  logic [CW-1:0]         cnt_b;
  logic [PH-1:0][CW-1:0] xpt;

  assign both_run = run_a && run_b;
  assign any_run  = run_a || run_b;

  cpwm3_regs #(.CW(CW), .PH(PH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_a(run_a), .run_b(run_b), .start_pulse(start_pulse), .ld_a(ld_a), .ld_b(ld_b),
    .wr_dropped(wr_dropped), .period(period), .xpt(xpt)
  );

  cpwm3_tri_pair #(.CW(CW)) u_tri (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run_a(run_a), .run_b(run_b),
    .start_pulse(start_pulse), .ld_a(ld_a), .ld_b(ld_b), .ld_val(wr_data),
    .period(period), .cnt_a(cnt_a), .cnt_b(cnt_b), .dir_up(dir_up)
  );

  for (genvar g = 0; g < PH; g++) begin : g_phase
    cpwm3_phase_out #(.CW(CW)) u_ph (
      .clk(clk), .rst_n(rst_n), .active(both_run), .cnt_a(cnt_a), .cnt_b(cnt_b),
      .xpt(xpt[g]), .pos_q(pwm_p[g]), .neg_q(pwm_n[g])
    );
  end

  cpwm3_cfg_check #(.CW(CW), .PH(PH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .xpt(xpt), .err_same(err_same), .err_margin(err_margin)
  );
endmodule

// File: rtl/cpwm3_checker.sv
`timescale 1ns/1ps
module cpwm3_checker #(
  parameter int CW = 16,
  parameter int PH = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          both_run,
  input logic          wr_dropped,
  input logic          start_pulse,
  input logic          dir_up,
  input logic [CW-1:0] period,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [PH-1:0] pwm_p,
  input logic [PH-1:0] pwm_n,
  input logic          err_same,
  input logic          err_margin
);
  AST_LOCKED_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |=> $stable(period)); // R1
  AST_NO_EN_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (both_run && !cnt_en) |=> ($stable(cnt_a) && $stable(cnt_b))); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (both_run && cnt_en) |=> ((cnt_a - cnt_b) == $past(cnt_a - cnt_b))); // R3
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_p & pwm_n) == '0)); // R5
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !both_run |=> ((pwm_p == '0) && (pwm_n == '0))); // R6
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |=> ($stable(err_same) && $stable(err_margin))); // R7
  AST_START_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> dir_up); // R9
endmodule

bind cpwm3_timer cpwm3_checker #(.CW(CW), .PH(PH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .both_run(both_run),
  .wr_dropped(wr_dropped), .start_pulse(start_pulse), .dir_up(dir_up),
  .period(period), .cnt_a(cnt_a), .cnt_b(cnt_b), .pwm_p(pwm_p), .pwm_n(pwm_n),
  .err_same(err_same), .err_margin(err_margin)
);

// File: tb/cpwm3_timer_bench.sv
`timescale 1ns/1ps
module cpwm3_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  pwm_p;
  logic [2:0]  pwm_n;
  logic        err_same;
  logic        err_margin;

  always #2.5 clk = ~clk;

  cpwm3_timer u_cpwm3_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_p(pwm_p), .pwm_n(pwm_n), .err_same(err_same),
    .err_margin(err_margin)
  );

  int total = 0;
  int bad = 0;
  string tag = "R6";

  // bench-side model state
  int mA = 0, mB = 0, mP = 0;
  int mX[3] = '{0, 0, 0};
  bit mRa = 0, mRb = 0, mUp = 1, mEs = 0, mEm = 0;
  int cyc_no = 0;
  bit gap_on = 0;
  int gap_exp = 0;
  int last_fall[3] = '{-1, -1, -1};
  logic [2:0] prev_p = '0, prev_n = '0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int wrap16(input int v);
    return v & 32'hFFFF;
  endfunction

  task automatic cyc(input bit we, input int adr, input int dat, input bit en);
    bit both, anyr, start, turn, nup;
    logic [2:0] ep, en_n;
    int nA, nB;
    wr_en = we; wr_addr = 3'(adr); wr_data = 16'(dat); cnt_en = en;
    both = mRa && mRb;
    anyr = mRa || mRb;
    for (int i = 0; i < 3; i++) begin
      ep[i]   = both && (mA < mX[i]);
      en_n[i] = both && (mB >= mX[i]);
    end
    start = we && adr == 0 && (dat & 3) == 3 && !both;
    if (start) begin
      mEs = (mA == mB);
      mEm = (mX[0] < mA) || (mX[1] < mA) || (mX[2] < mA);
    end
    turn = both && en && (mUp ? (mA == mP + 1) : (mB == 0));
    nup = mUp ^ turn;
    nA = mA; nB = mB;
    if (we && !anyr && adr == 1) nA = dat;
    else if (mRa && en) nA = wrap16(mA + (nup ? 1 : -1));
    if (we && !anyr && adr == 2) nB = dat;
    else if (mRb && en) nB = wrap16(mB + (nup ? 1 : -1));
    mA = nA; mB = nB;
    if (we && !anyr && adr == 3) mP = dat;
    if (we && !anyr && adr >= 4 && adr <= 6) mX[adr-4] = dat;
    if (we && adr == 0) begin mRa = dat[0]; mRb = dat[1]; end
    mUp = start ? 1'b1 : nup;
    @(posedge clk);
    @(negedge clk);
    cyc_no++;
    check(pwm_p == ep, "pwm_p", int'(pwm_p), int'(ep));
    check(pwm_n == en_n, "pwm_n", int'(pwm_n), int'(en_n));
    check(err_same == mEs, "err_same", int'(err_same), int'(mEs));
    check(err_margin == mEm, "err_margin", int'(err_margin), int'(mEm));
    check((pwm_p & pwm_n) == 3'b000, "R5 overlap", int'(pwm_p & pwm_n), 0);
    wr_en = 1'b0;
    if (gap_on) begin
      for (int i = 0; i < 3; i++) begin
        if (prev_p[i] && !pwm_p[i]) last_fall[i] = cyc_no;
        if (!prev_n[i] && pwm_n[i] && last_fall[i] >= 0)
          check(cyc_no - last_fall[i] == gap_exp, "R5 dead gap", cyc_no - last_fall[i], gap_exp);
      end
    end
    prev_p = pwm_p; prev_n = pwm_n;
  endtask

  task automatic idle(input int n, input bit en);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, en);
  endtask

  task automatic setup(input int a, input int b, input int p, input int x0, input int x1, input int x2);
    cyc(1, 0, 0, 1);
    cyc(1, 1, a, 1);
    cyc(1, 2, b, 1);
    cyc(1, 3, p, 1);
    cyc(1, 4, x0, 1);
    cyc(1, 5, x1, 1);
    cyc(1, 6, x2, 1);
    cyc(1, 0, 3, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc_no);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R6 reset";
    check(pwm_p == 0 && pwm_n == 0, "reset outputs", int'({pwm_p, pwm_n}), 0);
    check(!err_same && !err_margin, "reset flags", int'({err_same, err_margin}), 0);

    tag = "R4 R3 directed";
    gap_exp = 3; gap_on = 1;
    setup(3, 0, 20, 6, 10, 14);
    tag = "R5 R4";
    idle(80, 1);
    gap_on = 0;

    tag = "R1 locked writes";
    cyc(1, 4, 1, 1);
    cyc(1, 1, 0, 1);
    cyc(1, 3, 5, 1);
    cyc(1, 2, 9, 1);
    idle(50, 1);

    tag = "R2 enable gaps";
    for (int k = 0; k < 80; k++) cyc(0, 0, 0, ($urandom % 3) != 0);

    tag = "R6 stopped";
    cyc(1, 0, 0, 1);
    idle(6, 1);
    check(pwm_p == 0 && pwm_n == 0, "outputs idle", int'({pwm_p, pwm_n}), 0);

    tag = "R7 equal preload";
    setup(5, 5, 20, 6, 8, 10);
    check(err_same == 1'b1, "err_same raised", int'(err_same), 1);
    idle(10, 1);

    tag = "R8 below margin";
    setup(4, 0, 20, 3, 10, 12);
    check(err_margin == 1'b1, "err_margin raised", int'(err_margin), 1);
    check(err_same == 1'b0, "err_same cleared", int'(err_same), 0);
    idle(10, 1);
    tag = "R8 equal to margin";
    setup(4, 0, 20, 4, 10, 12);
    check(err_margin == 1'b0, "err_margin clear", int'(err_margin), 0);
    idle(20, 1);

    tag = "R9 restart";
    setup(2, 0, 15, 4, 7, 9);
    idle(25, 1);
    gap_exp = 2; gap_on = 1;
    last_fall = '{-1, -1, -1};
    setup(2, 0, 15, 4, 7, 9);
    idle(40, 1);
    gap_on = 0;

    tag = "R4 random";
    for (int it = 0; it < 15; it++) begin
      int m, p, x0, x1, x2, span;
      m = 1 + int'($urandom % 6);
      p = 2 * m + 6 + int'($urandom % 40);
      span = p + 2 - 2 * m;
      x0 = m + int'($urandom % span);
      x1 = m + int'($urandom % span);
      x2 = m + int'($urandom % span);
      setup(m, 0, p, x0, x1, x2);
      for (int k = 0; k < 4 * (p + 1 - m); k++) cyc(0, 0, 0, ($urandom % 4) != 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule